// File: doc/BRIEF.md
# Current Source Calibration Rotation Scheduler

This block produces the digital switch timing for a bank of identical current sources in a converter. The bank has one more source than there are output slots. At any moment every source but one is routed to an output slot, and the remaining source is tied to the reference so it can be recalibrated. When that calibration ends, the freshly calibrated source takes over the slot of the next source in line, and that source goes into calibration in turn. Calibration therefore never stops, and no slot is left without a source for longer than one guard cycle.

For every source the block drives a calibrate switch (the source is tied to the reference) and an output switch (the source is connected to its slot). For every slot it drives a steering select that names the source feeding that slot. The calibration dwell comes from a configuration input that is captured while reset is asserted. A status output reports which source is currently being calibrated.

Each handover takes three steps. First the calibrate switch opens while every output stays as it was. Next the source that will be calibrated next lets go of its slot, which leaves that slot undriven for one cycle. Finally the calibrated source drives that slot, and the released source closes its calibrate switch.

Top module: `ccal_rot_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, source index N_SLOT (32 by default) is in calibration, slot i selects source i for every slot, `cal_idx` equals N_SLOT, and every output switch except that of source N_SLOT is closed.
- R2: Each calibrate switch stays closed for exactly max(dwell_cfg, 1) consecutive cycles. `dwell_cfg` is captured only while `rst_n` is low, and a change to it after reset has no effect on the timing.
- R3: When a calibration ends there is one cycle in which every calibrate switch is open, while the output switches and slot selects are unchanged from the previous cycle.
- R4: In the next cycle the output switch of the next source to be calibrated is open. The slot that source was feeding then has no driver, for exactly one cycle.
- R5: In the cycle after that, the slot select of that slot names the source that has just been calibrated, its output switch is closed, and the calibrate switch of the next source is closed.
- R6: Sources are calibrated in the order c, then (c+1) mod (N_SLOT+1).
- R7: At most one calibrate switch is closed at any time, and no source ever has both its calibrate switch and its output switch closed.
- R8: In every cycle each slot is driven by exactly one source (the output switch of its selected source is closed), except the single undriven slot of R4. No source is selected by two slots.
- R9: Within one rotation of (N_SLOT+1)·(max(dwell_cfg,1)+2) cycles after reset, each source starts calibration exactly once.
- R10: `cal_idx` names the source whose calibration is in progress, from its first calibrate cycle until its handover is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dwell_cfg | input | DWELL_W | Calibration dwell in cycles, captured during reset (0 is treated as 1) |
| cal_sw | output | N_SLOT+1 | Per-source calibrate switch, 1 = tied to the reference |
| out_sw | output | N_SLOT+1 | Per-source output switch, 1 = connected to its slot |
| slot_sel | output | N_SLOT*SEL_W | Per-slot steering select; slot i is bits [i*SEL_W +: SEL_W] |
| cal_idx | output | SEL_W | Index of the source in calibration |

## Verification
The bench sweeps dwell settings of 0, 1, 2 and 5. For each one it predicts every switch, select and status value in every cycle over two full rotations, using a cycle-position model and its own slot table. A dwell of zero must behave exactly like one; a design that counted it literally would hold the calibrate switch for a full counter wrap or skip the phase. The dwell input is changed in mid-run, so a design that tracks the live input rather than the captured value shows a shorter or longer calibrate run. The guard cycles are checked cycle by cycle: a design that merged the open step into the handover, or released the next source a cycle late, would show a slot with two drivers or none outside the one allowed cycle. Wrong slot bookkeeping shows up as a select that diverges from the predicted table, or as a source that is routed to two slots.

// File: rtl/ccal_pkg.sv
// Package: shared types for the calibration rotation scheduler.
// Assumes the phase encoding is private to the block.
package ccal_pkg;

    // Handover phases of the rotation
    typedef enum logic [1:0] {
        PH_CAL   = 2'd0,   // selected source tied to reference
        PH_OPEN  = 2'd1,   // calibrate switch opened, outputs frozen
        PH_BREAK = 2'd2    // next source released from its slot
    } phase_t;

endpackage

// File: rtl/ccal_sequencer.sv
// Module: ccal_sequencer
// Walks the handover phases and counts the calibration dwell. It also
// keeps the index of the source in calibration and of the next one in
// round-robin order.
// Assumes: the dwell is captured during reset, and a dwell of 0 is
// promoted to 1.
module ccal_sequencer
    import ccal_pkg::*;
#(
    parameter int NSRC    = 33,
    parameter int SEL_W   = 6,
    parameter int DWELL_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DWELL_W-1:0] dwell_cfg,
    output phase_t             phase,
    output logic [SEL_W-1:0]   cur_src,
    output logic [SEL_W-1:0]   nxt_src,
    output logic               handover
);

    localparam logic [SEL_W-1:0] LAST_SRC = SEL_W'(NSRC - 1);

    logic [DWELL_W-1:0] dwell_q;
    logic [DWELL_W-1:0] cnt_q;

    // Next source in rotation, wrapping after the last index
    always_comb begin
        nxt_src = (cur_src == LAST_SRC) ? '0 : cur_src + 1'b1;
    end

    // The slot table updates on the edge that ends the break phase
    assign handover = (phase == PH_BREAK);

    // Phase, dwell counter and current-source register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dwell_q <= (dwell_cfg == '0) ? DWELL_W'(1) : dwell_cfg;
            cnt_q   <= '0;
            phase   <= PH_CAL;
            cur_src <= LAST_SRC;
        end else begin
            unique case (phase)
                PH_CAL: begin
                    if (cnt_q == dwell_q - 1'b1) begin
                        cnt_q <= '0;
                        phase <= PH_OPEN;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_OPEN: begin
                    phase <= PH_BREAK;
                end
                PH_BREAK: begin
                    phase   <= PH_CAL;
                    cur_src <= nxt_src;
                end
                default: begin
                    phase <= PH_CAL;
                end
            endcase
        end
    end

endmodule

// File: rtl/ccal_slot_map.sv
// Module: ccal_slot_map
// Keeps the slot-to-source table and its inverse. On a handover the
// just-calibrated source takes over the slot of the next source.
// Assumes N_SLOT >= 2. The inverse entry of the source in calibration
// is stale and never read.
module ccal_slot_map #(
    parameter int N_SLOT = 32,
    parameter int NSRC   = 33,
    parameter int SEL_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    handover,
    input  logic [SEL_W-1:0]        cur_src,
    input  logic [SEL_W-1:0]        nxt_src,
    output logic [N_SLOT*SEL_W-1:0] slot_sel
);

    localparam int SLOT_W = $clog2(N_SLOT);

    logic [SEL_W-1:0]  src_of_slot [N_SLOT];
    logic [SLOT_W-1:0] slot_of_src [NSRC];
    logic [SLOT_W-1:0] vacated;

    // Slot that the next source is about to leave
    assign vacated = slot_of_src[nxt_src];

    // Identity map at reset; swap in the calibrated source on handover
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SLOT; i++) begin
                src_of_slot[i] <= SEL_W'(i);
            end
            for (int j = 0; j < NSRC; j++) begin
                slot_of_src[j] <= (j < N_SLOT) ? SLOT_W'(j) : '0;
            end
        end else if (handover) begin
            src_of_slot[vacated] <= cur_src;
            slot_of_src[cur_src] <= vacated;
        end
    end

    // Flatten the table onto the select bus
    genvar g;
    generate
        for (g = 0; g < N_SLOT; g++) begin : g_sel
            assign slot_sel[g*SEL_W +: SEL_W] = src_of_slot[g];
        end
    endgenerate

endmodule

// File: rtl/ccal_switch_drv.sv
// Module: ccal_switch_drv
// Decodes the phase and the source indices into per-source calibrate
// and output switch levels.
// Assumes the indices are stable for the whole cycle.
module ccal_switch_drv
    import ccal_pkg::*;
#(
    parameter int NSRC  = 33,
    parameter int SEL_W = 6
) (
    input  phase_t            phase,
    input  logic [SEL_W-1:0]  cur_src,
    input  logic [SEL_W-1:0]  nxt_src,
    output logic [NSRC-1:0]   cal_sw,
    output logic [NSRC-1:0]   out_sw
);

    genvar s;
    generate
        for (s = 0; s < NSRC; s++) begin : g_src
            logic is_cur;
            logic is_nxt;
            assign is_cur = (cur_src == SEL_W'(s));
            assign is_nxt = (nxt_src == SEL_W'(s));
            // Calibrate switch closes only during the dwell of this source
            assign cal_sw[s] = is_cur && (phase == PH_CAL);
            // Output switch opens while calibrating or while being released
            assign out_sw[s] = !is_cur && !(is_nxt && (phase == PH_BREAK));
        end
    endgenerate

endmodule

// File: rtl/ccal_rot_sched.sv
// Module: ccal_rot_sched (top)
// Calibration rotation scheduler: a bank of N_SLOT+1 sources feeds
// N_SLOT slots while one spare at a time is recalibrated.
// Assumes synchronous active-low reset and dwell_cfg steady during reset.
module ccal_rot_sched #(
    parameter int N_SLOT  = 32,
    parameter int DWELL_W = 16,
    localparam int NSRC   = N_SLOT + 1,
    localparam int SEL_W  = $clog2(NSRC)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DWELL_W-1:0]      dwell_cfg,
    output logic [NSRC-1:0]         cal_sw,
    output logic [NSRC-1:0]         out_sw,
    output logic [N_SLOT*SEL_W-1:0] slot_sel,
    output logic [SEL_W-1:0]        cal_idx
);

    import ccal_pkg::*;

    phase_t           phase;
    logic [SEL_W-1:0] cur_src;
    logic [SEL_W-1:0] nxt_src;
    logic             handover;

    // Phase sequencing and dwell timing
    ccal_sequencer #(
        .NSRC(NSRC), .SEL_W(SEL_W), .DWELL_W(DWELL_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .dwell_cfg(dwell_cfg),
        .phase(phase), .cur_src(cur_src), .nxt_src(nxt_src),
        .handover(handover)
    );

    // Slot steering table
    ccal_slot_map #(
        .N_SLOT(N_SLOT), .NSRC(NSRC), .SEL_W(SEL_W)
    ) u_map (
        .clk(clk), .rst_n(rst_n), .handover(handover),
        .cur_src(cur_src), .nxt_src(nxt_src), .slot_sel(slot_sel)
    );

    // Per-source switch decode
    ccal_switch_drv #(
        .NSRC(NSRC), .SEL_W(SEL_W)
    ) u_drv (
        .phase(phase), .cur_src(cur_src), .nxt_src(nxt_src),
        .cal_sw(cal_sw), .out_sw(out_sw)
    );

    // Status: source whose calibration cycle is in progress
    assign cal_idx = cur_src;

endmodule

// File: rtl/ccal_rot_checker.sv
// Module: ccal_rot_checker
// Port-level properties of the rotation scheduler, bound to the top.
module ccal_rot_checker #(
    parameter int N_SLOT = 32,
    parameter int SEL_W  = 6,
    localparam int NSRC  = N_SLOT + 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NSRC-1:0]         cal_sw,
    input logic [NSRC-1:0]         out_sw,
    input logic [N_SLOT*SEL_W-1:0] slot_sel,
    input logic [SEL_W-1:0]        cal_idx
);

    AST_ONE_CAL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cal_sw) <= 1); // R7

    AST_CAL_OUT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_sw & out_sw) == '0); // R7

    AST_CAL_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_sw != '0) |-> cal_sw[cal_idx]); // R10

    AST_OPEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|cal_sw) |-> ($stable(out_sw) && $stable(slot_sel))); // R3

    AST_BREAK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(out_sw) == N_SLOT - 1) |=> ($countones(out_sw) == N_SLOT)); // R4

    AST_MIN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(out_sw) >= N_SLOT - 1); // R8

    AST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|cal_sw) |-> (($past(cal_idx) == SEL_W'(NSRC - 1)) ?
            (cal_idx == '0) : (cal_idx == $past(cal_idx) + 1'b1))); // R6

endmodule

bind ccal_rot_sched ccal_rot_checker #(
    .N_SLOT(N_SLOT), .SEL_W(SEL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cal_sw(cal_sw), .out_sw(out_sw),
    .slot_sel(slot_sel), .cal_idx(cal_idx)
);

// File: tb/sim_ccal_rot_sched.sv
// Bench: sweeps dwell settings and predicts every output in every cycle.
module sim_ccal_rot_sched;

    localparam int CLK_PERIOD = 10;
    localparam int NS    = 32;
    localparam int NSRC  = NS + 1;
    localparam int SW    = $clog2(NSRC);
    localparam int DW    = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [DW-1:0]      dwell_cfg = '0;
    logic [NSRC-1:0]    cal_sw;
    logic [NSRC-1:0]    out_sw;
    logic [NS*SW-1:0]   slot_sel;
    logic [SW-1:0]      cal_idx;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;
    int emap [NS];
    int starts [NSRC];
    logic [NSRC-1:0] prev_cal;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccal_rot_sched #(.N_SLOT(NS), .DWELL_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .dwell_cfg(dwell_cfg),
        .cal_sw(cal_sw), .out_sw(out_sw), .slot_sel(slot_sel),
        .cal_idx(cal_idx)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare all outputs against the model at cycle position k
    task automatic check_cycle(input int k, input int deff);
        int per, ph, cur, nxt, undriven;
        logic [NSRC-1:0] ecal, eout, used;
        logic [NS*SW-1:0] esel;
        per = deff + 2;
        ph  = k % per;
        cur = (NS + k / per) % NSRC;
        nxt = (cur + 1) % NSRC;
        if (ph == 0 && k > 0) begin
            // R5: just-calibrated source takes the slot of the new one
            for (int p = 0; p < NS; p++)
                if (emap[p] == cur) emap[p] = (cur + NSRC - 1) % NSRC;
        end
        ecal = '0;
        if (ph < deff) ecal[cur] = 1'b1;
        eout = '1;
        eout[cur] = 1'b0;
        if (ph == deff + 1) eout[nxt] = 1'b0;
        for (int p = 0; p < NS; p++) esel[p*SW +: SW] = SW'(emap[p]);
        check(cal_sw == ecal, (ph < deff) ? "R2" : "R3", "cal_sw", cal_sw, ecal);
        check(out_sw == eout, (ph == deff + 1) ? "R4" : "R5", "out_sw", out_sw, eout);
        check(slot_sel == esel, "R5", "slot_sel", slot_sel[63:0], esel[63:0]);
        check(cal_idx == SW'(cur), "R10", "cal_idx", cal_idx, cur);
        // R8: drivers counted from the outputs alone
        undriven = 0;
        used = '0;
        for (int p = 0; p < NS; p++) begin
            int s;
            s = int'(slot_sel[p*SW +: SW]);
            if (s >= NSRC || !out_sw[s]) undriven++;
            else begin
                if (used[s]) undriven += 100;
                used[s] = 1'b1;
            end
        end
        check(undriven == ((ph == deff + 1) ? 1 : 0), "R8", "undriven", undriven,
              (ph == deff + 1) ? 1 : 0);
        check((cal_sw & out_sw) == '0, "R7", "cal_and_out", cal_sw & out_sw, 0);
    endtask

    task automatic run_cfg(input int cfg);
        int deff, per, nrun;
        deff = (cfg == 0) ? 1 : cfg;
        per  = deff + 2;
        nrun = 2 * NSRC * per + 3;
        @(negedge clk);
        rst_n = 1'b0;
        dwell_cfg = DW'(cfg);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int p = 0; p < NS; p++) emap[p] = p;
        for (int s = 0; s < NSRC; s++) starts[s] = 0;
        #1;
        // R1: reset state
        check(cal_sw == (NSRC'(1) << NS), "R1", "reset cal_sw", cal_sw, NSRC'(1) << NS);
        check(cal_idx == SW'(NS), "R1", "reset cal_idx", cal_idx, NS);
        check_cycle(0, deff);
        prev_cal = '0;
        for (int k = 0; k < nrun; k++) begin
            if (k > 0) begin
                @(negedge clk);
                #1;
                check_cycle(k, deff);
            end
            if (k < NSRC * per)
                for (int s = 0; s < NSRC; s++)
                    if (cal_sw[s] && !prev_cal[s]) starts[s]++;
            prev_cal = cal_sw;
            // R2: change after reset must be ignored
            if (k == 5 * per) dwell_cfg = DW'(cfg + 3);
        end
        for (int s = 0; s < NSRC; s++)
            check(starts[s] == 1, "R9", "starts per rotation", starts[s], 1);
        // R6: order already covered per cycle via cal_idx; confirm wrap point
        check(cal_idx == SW'((NS + (nrun - 1) / per) % NSRC), "R6", "order",
              cal_idx, (NS + (nrun - 1) / per) % NSRC);
    endtask

    initial begin
        run_cfg(0);
        run_cfg(1);
        run_cfg(2);
        run_cfg(5);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule